// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block holds the configuration and per-line state of an interrupt controller that serves up to 256 interrupt lines and up to 8 CPUs. For every line it stores an enable bit, a pending bit and an active bit. It also stores an 8-bit priority, an 8-bit CPU-target field and a 2-bit trigger configuration. A global enable and a read-only type word complete the register set. Software reaches the bank over a simple register bus. Each request carries a byte offset, a size of 1, 2 or 4 bytes, write data and the index of the requesting CPU. The response comes back one cycle later.

The three single-bit states are each written through two windows. A write to the set window ORs the data into the state word. A write to the clear window removes the data bits from it, so software changes one bit without a read-modify-write. Enable, pending and active bits for lines 0 to 31 are banked per CPU. Lines 32 and above share one copy. The bank drives every state vector out as a flat port for the arbitration logic. It raises a one-cycle update pulse whenever a write may change which interrupt should be signalled.

Top module: `dist_regbank`

## Requirements
- R1: A write to a set window (enable 0x100, pending 0x200, active 0x300, plus 4 per 32-line word) ORs the data into the addressed 32-bit state word. A write to the clear window at the same offset plus 0x80 clears every bit that is 1 in the data. The word index is (offset − window base) >> 2.
- R2: A read of a set window and a read of the matching clear window both return the current state word.
- R3: In writes to pending word 0, data bits 15:0 (the software-generated lines) are ignored in both the set and the clear window. The active and enable windows have no such protection.
- R4: Priority bytes sit at 0x400 + line. A 1-, 2- or 4-byte access covers lines n to n+size−1, packed little-endian with line n in bits 7:0. An access that runs past the last line is an error.
- R5: Target bytes sit at 0x800 + line. For lines 32 and above they accept 1- and 4-byte accesses. A 4-byte access aligns the line number down to a multiple of 4. A 2-byte target access is an error.
- R6: A target read for a line below 32 returns the requester's one-hot mask (1 << cpu) in each byte read, so a 4-byte read repeats the mask in all four bytes. Writes to those targets leave the stored target unchanged.
- R7: The type word at 0x004 reads ((NUM_CPUS−1) << 5) | (NUM_LINES/32 − 1), which is 0x61 with the defaults. Writes to it are ignored.
- R8: Bit 0 of the control word at 0x000 holds the global enable, shown on `dist_enable`. Configuration words at 0xC00 + 4·k hold lines 16k to 16k+15 at two bits each. They are stored as written and read back unchanged.
- R9: `upd_pulse` is high for one cycle, in the response cycle, after every accepted write to a pending window, a priority byte or a target byte of line 32 or above. It stays low for every other access.
- R10: An access to an unmapped offset, with a size other than 1, 2 or 4, past the last implemented line or word, or from a CPU index of NUM_CPUS or above sets `rsp_err`, returns zero data and changes no state.
- R11: Enable, pending and active word 0 are banked per CPU and selected by `req_cpu`. The words for lines 32 and above are shared by all CPUs. Each CPU's view appears in its own NUM_LINES-bit slice of the state vectors.
- R12: Each request in cycle t produces `rsp_valid` in cycle t+1, with read data, error flag and update pulse in that same cycle. Writes return zero data. Word registers ignore offset bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset into the register map |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| req_cpu | input | 3 | Index of the requesting CPU |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Request was rejected |
| upd_pulse | output | 1 | Arbitration state must be recomputed |
| dist_enable | output | 1 | Global enable |
| en_vec | output | NUM_CPUS*NUM_LINES | Enable bits, one slice per CPU view |
| pend_vec | output | NUM_CPUS*NUM_LINES | Pending bits, one slice per CPU view |
| act_vec | output | NUM_CPUS*NUM_LINES | Active bits, one slice per CPU view |
| prio_vec | output | NUM_LINES*8 | Priority byte per line |
| tgt_vec | output | NUM_LINES*8 | Target byte per line |
| cfg_vec | output | NUM_LINES*2 | Trigger configuration per line |

## Verification
The bench walks the corners where a register bank of this kind goes wrong. A set and a clear of overlapping bits in the same word must leave the set-minus-clear value visible through both windows. A design that dropped protection of the software lines would show ones in the low half of pending word 0. One that shared word 0 across CPUs would let one CPU's enable appear in another CPU's view. Priority accesses at unaligned offsets must pack bytes in the right order, and a 4-byte target write at an unaligned offset must land on the aligned group. Low-line target reads must show the caller's own mask, and writes to those targets must not reach `tgt_vec`. Rejected accesses must neither change state nor pulse the update line.

// File: rtl/dist_pkg.sv
package dist_pkg;
  localparam int ADDR_W = 12;

  typedef enum logic [3:0] {
    W_NONE, W_CTRL, W_TYPE,
    W_EN_SET, W_EN_CLR, W_PD_SET, W_PD_CLR, W_AC_SET, W_AC_CLR,
    W_PRIO, W_TGT, W_CFG
  } win_e;

  // software-generated lines whose pending bits are write-protected
  localparam logic [31:0] SOFT_LINES = 32'h0000_FFFF;
endpackage

// File: rtl/dist_decode.sv
module dist_decode
  import dist_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [2:0]        cpu,
  output win_e              win,
  output logic [9:0]        idx,
  output logic              bad
);
  localparam int WORDS     = NUM_LINES / 32;
  localparam int CFG_WORDS = NUM_LINES / 16;

  win_e        w;
  logic        range_ok;
  logic        size_ok;
  logic [10:0] end_byte;

  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

  always_comb begin
    w        = W_NONE;
    idx      = '0;
    range_ok = 1'b1;
    end_byte = '0;
    if (addr[11:3] == '0) begin
      w = addr[2] ? W_TYPE : W_CTRL;
    end else if (addr[11:10] == 2'b00 && addr[9:8] != 2'b00) begin
      idx      = {5'd0, addr[6:2]};
      range_ok = int'(addr[6:2]) < WORDS;
      unique case ({addr[9:8], addr[7]})
        3'b010:  w = W_EN_SET;
        3'b011:  w = W_EN_CLR;
        3'b100:  w = W_PD_SET;
        3'b101:  w = W_PD_CLR;
        3'b110:  w = W_AC_SET;
        default: w = W_AC_CLR;
      endcase
    end else if (addr[11:10] == 2'b01) begin
      w        = W_PRIO;
      idx      = addr[9:0];
      end_byte = {1'b0, addr[9:0]} + {8'd0, size};
      range_ok = int'(end_byte) <= NUM_LINES;
    end else if (addr[11:10] == 2'b10) begin
      w        = W_TGT;
      idx      = (size == 3'd4) ? {addr[9:2], 2'b00} : addr[9:0];
      end_byte = {1'b0, idx} + {8'd0, size};
      range_ok = (size != 3'd2) && (int'(end_byte) <= NUM_LINES);
    end else if (addr[11:10] == 2'b11) begin
      w        = W_CFG;
      idx      = {2'b00, addr[9:2]};
      range_ok = int'(addr[9:2]) < CFG_WORDS;
    end
  end

  assign bad = !size_ok || (w == W_NONE) || !range_ok || (int'(cpu) >= NUM_CPUS);
  assign win = bad ? W_NONE : w;
endmodule

// File: rtl/dist_bitstate.sv
module dist_bitstate #(
  parameter int          NUM_LINES = 64,
  parameter int          NUM_CPUS  = 4,
  parameter logic [31:0] PROT_MASK = 32'h0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          set_we,
  input  logic                          clr_we,
  input  logic [2:0]                    cpu,
  input  logic [4:0]                    widx,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rword,
  output logic [NUM_CPUS*NUM_LINES-1:0] view
);
  localparam int WORDS = NUM_LINES / 32;

  logic [NUM_CPUS-1:0][31:0] bank;
  logic [WORDS-1:1][31:0]    shared;
  logic [31:0]               mask;

  assign mask = (widx == 5'd0) ? (wdata & ~PROT_MASK) : wdata;

  function automatic logic [31:0] apply(input logic [31:0] cur, input logic [31:0] m,
                                        input logic s);
    return s ? (cur | m) : (cur & ~m);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      bank   <= '0;
      shared <= '0;
    end else if (set_we || clr_we) begin
      for (int c = 0; c < NUM_CPUS; c++)
        if (widx == 5'd0 && cpu == 3'(c)) bank[c] <= apply(bank[c], mask, set_we);
      for (int w = 1; w < WORDS; w++)
        if (widx == 5'(w)) shared[w] <= apply(shared[w], mask, set_we);
    end
  end

  always_comb begin
    rword = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (widx == 5'd0 && cpu == 3'(c)) rword = bank[c];
    for (int w = 1; w < WORDS; w++)
      if (widx == 5'(w)) rword = shared[w];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_view
    assign view[c*NUM_LINES +: 32] = bank[c];
    for (genvar w = 1; w < WORDS; w++) begin : g_word
      assign view[c*NUM_LINES + w*32 +: 32] = shared[w];
    end
    if (PROT_MASK != 32'h0) begin : g_prot
      // R3: protected bits never change after reset
      p_soft_locked_r3: assert property (@(posedge clk) disable iff (rst)
        $stable(bank[c] & PROT_MASK));
    end
  end
endmodule

// File: rtl/dist_bytefile.sv
module dist_bytefile #(
  parameter int NUM_LINES = 64,
  parameter bit LOW_RO    = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [9:0]             n,
  input  logic [2:0]             size,
  input  logic [31:0]            wdata,
  input  logic [2:0]             cpu,
  output logic [31:0]            rdata,
  output logic [NUM_LINES*8-1:0] flat
);
  logic [7:0] mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) mem[i] <= '0;
    end else if (we) begin
      for (int k = 0; k < 4; k++)
        if (k < int'(size) && int'(n) + k < NUM_LINES && !(LOW_RO && int'(n) + k < 32))
          mem[int'(n) + k] <= wdata[8*k +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(size)) begin
        if (LOW_RO && int'(n) + k < 32) rdata[8*k +: 8] = 8'(1 << cpu);
        else if (int'(n) + k < NUM_LINES) rdata[8*k +: 8] = mem[int'(n) + k];
      end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_flat
    assign flat[i*8 +: 8] = mem[i];
    if (LOW_RO && i < 32) begin : g_lock
      // R6: low-line targets are never stored
      p_low_target_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        $stable(mem[i]));
    end
  end
endmodule

// File: rtl/dist_regbank.sv
module dist_regbank
  import dist_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [11:0]                   req_addr,
  input  logic [2:0]                    req_size,
  input  logic [31:0]                   req_wdata,
  input  logic [2:0]                    req_cpu,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  output logic                          rsp_err,
  output logic                          upd_pulse,
  output logic                          dist_enable,
  output logic [NUM_CPUS*NUM_LINES-1:0] en_vec,
  output logic [NUM_CPUS*NUM_LINES-1:0] pend_vec,
  output logic [NUM_CPUS*NUM_LINES-1:0] act_vec,
  output logic [NUM_LINES*8-1:0]        prio_vec,
  output logic [NUM_LINES*8-1:0]        tgt_vec,
  output logic [NUM_LINES*2-1:0]        cfg_vec
);
  localparam int          CFG_WORDS = NUM_LINES / 16;
  localparam logic [31:0] TYPE_WORD = 32'((NUM_CPUS - 1) << 5) | 32'(NUM_LINES / 32 - 1);

  win_e        win;
  logic [9:0]  idx;
  logic        bad;
  logic        acc, wr;
  logic [31:0] en_rd, pd_rd, ac_rd, pr_rd, tg_rd, rd_mux;
  logic [31:0] cfg_q [CFG_WORDS];
  logic        upd_next;

  dist_decode #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_dec (
    .addr(req_addr), .size(req_size), .cpu(req_cpu), .win(win), .idx(idx), .bad(bad));

  assign acc = req_valid && !bad;
  assign wr  = acc && req_write;

  dist_bitstate #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .PROT_MASK(32'h0)) u_en (
    .clk(clk), .rst(rst), .set_we(wr && win == W_EN_SET), .clr_we(wr && win == W_EN_CLR),
    .cpu(req_cpu), .widx(idx[4:0]), .wdata(req_wdata), .rword(en_rd), .view(en_vec));

  dist_bitstate #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .PROT_MASK(SOFT_LINES)) u_pd (
    .clk(clk), .rst(rst), .set_we(wr && win == W_PD_SET), .clr_we(wr && win == W_PD_CLR),
    .cpu(req_cpu), .widx(idx[4:0]), .wdata(req_wdata), .rword(pd_rd), .view(pend_vec));

  dist_bitstate #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .PROT_MASK(32'h0)) u_ac (
    .clk(clk), .rst(rst), .set_we(wr && win == W_AC_SET), .clr_we(wr && win == W_AC_CLR),
    .cpu(req_cpu), .widx(idx[4:0]), .wdata(req_wdata), .rword(ac_rd), .view(act_vec));

  dist_bytefile #(.NUM_LINES(NUM_LINES), .LOW_RO(1'b0)) u_prio (
    .clk(clk), .rst(rst), .we(wr && win == W_PRIO), .n(idx), .size(req_size),
    .wdata(req_wdata), .cpu(req_cpu), .rdata(pr_rd), .flat(prio_vec));

  dist_bytefile #(.NUM_LINES(NUM_LINES), .LOW_RO(1'b1)) u_tgt (
    .clk(clk), .rst(rst), .we(wr && win == W_TGT), .n(idx), .size(req_size),
    .wdata(req_wdata), .cpu(req_cpu), .rdata(tg_rd), .flat(tgt_vec));

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_enable <= 1'b0;
      for (int w = 0; w < CFG_WORDS; w++) cfg_q[w] <= '0;
    end else if (wr) begin
      if (win == W_CTRL) dist_enable <= req_wdata[0];
      for (int w = 0; w < CFG_WORDS; w++)
        if (win == W_CFG && idx == 10'(w)) cfg_q[w] <= req_wdata;
    end
  end

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    assign cfg_vec[w*32 +: 32] = cfg_q[w];
  end

  always_comb begin
    rd_mux = '0;
    unique case (win)
      W_CTRL:             rd_mux = {31'd0, dist_enable};
      W_TYPE:             rd_mux = TYPE_WORD;
      W_EN_SET, W_EN_CLR: rd_mux = en_rd;
      W_PD_SET, W_PD_CLR: rd_mux = pd_rd;
      W_AC_SET, W_AC_CLR: rd_mux = ac_rd;
      W_PRIO:             rd_mux = pr_rd;
      W_TGT:              rd_mux = tg_rd;
      W_CFG:
        for (int w = 0; w < CFG_WORDS; w++)
          if (idx == 10'(w)) rd_mux = cfg_q[w];
      default:            rd_mux = '0;
    endcase
  end

  assign upd_next = wr && (win == W_PD_SET || win == W_PD_CLR || win == W_PRIO ||
                           (win == W_TGT && idx >= 10'd32));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      upd_pulse <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (acc && !req_write) ? rd_mux : '0;
      upd_pulse <= upd_next;
    end
  end

  // R12: one response per request, one cycle later
  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R10: a rejected request carries no data
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));
  // R9: update pulse only answers a write
  p_upd_from_write_r9: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (rsp_valid && !rsp_err && $past(req_write)));
endmodule

// File: tb/test_dist_regbank.sv
module test_dist_regbank;
  localparam int NL = 64;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4, req_cpu = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, upd_pulse, dist_enable;
  logic [31:0] rsp_rdata;
  logic [NC*NL-1:0] en_vec, pend_vec, act_vec;
  logic [NL*8-1:0] prio_vec, tgt_vec;
  logic [NL*2-1:0] cfg_vec;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    logic        u;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  dist_regbank #(.NUM_LINES(NL), .NUM_CPUS(NC)) i_dist_regbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .upd_pulse(upd_pulse),
    .dist_enable(dist_enable), .en_vec(en_vec), .pend_vec(pend_vec), .act_vec(act_vec),
    .prio_vec(prio_vec), .tgt_vec(tgt_vec), .cfg_vec(cfg_vec));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [11:0] a, input logic [2:0] s,
                     input logic [31:0] d, input logic [2:0] c,
                     input logic [31:0] ed, input bit ee, input bit eu, input string tag);
    exp_t x;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s;
    req_wdata = d; req_cpu = c;
    x.d = ed; x.e = ee; x.u = eu; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk) req_valid = 1'b0;
  endtask

  // monitor: compares each response against the queued expectation
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        check("R12 response without request", 32'd1, 32'd0);
      end else begin
        exp_t x;
        x = q.pop_front();
        check(x.tag, {rsp_rdata[29:0], rsp_err, upd_pulse}, {x.d[29:0], x.e, x.u});
        check({x.tag, " hi"}, {30'd0, rsp_rdata[31:30]}, {30'd0, x.d[31:30]});
      end
    end
  end

  initial begin
    #(200000 * 10);
    check("watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    check("R11 reset enables", 32'(|en_vec), 32'd0);
    check("R1 reset pending", 32'(|pend_vec), 32'd0);
    check("R8 reset enable/response", {29'd0, dist_enable, rsp_valid, upd_pulse}, 32'd0);

    acc(0, 12'h004, 4, 0, 0, 32'h61, 0, 0, "R7 type read");
    acc(1, 12'h004, 4, 32'hFFFF, 0, 0, 0, 0, "R7 type write");
    acc(0, 12'h006, 4, 0, 0, 32'h61, 0, 0, "R12 type low bits ignored");
    acc(1, 12'h000, 4, 1, 0, 0, 0, 0, "R8 ctrl write");
    acc(0, 12'h000, 4, 0, 2, 1, 0, 0, "R8 ctrl read");
    acc(1, 12'hC04, 4, 32'hA5A50F0F, 0, 0, 0, 0, "R8 cfg write");
    acc(0, 12'hC04, 4, 0, 1, 32'hA5A50F0F, 0, 0, "R8 cfg read");

    acc(1, 12'h104, 4, 32'h0F0, 0, 0, 0, 0, "R1 set enable");
    acc(1, 12'h104, 4, 32'hF00, 1, 0, 0, 0, "R1 set enable 2");
    acc(1, 12'h184, 4, 32'h030, 2, 0, 0, 0, "R1 clear enable");
    acc(0, 12'h104, 4, 0, 3, 32'hFC0, 0, 0, "R2 read set window");
    acc(0, 12'h184, 4, 0, 0, 32'hFC0, 0, 0, "R2 read clear window");

    acc(1, 12'h100, 4, 32'h1, 1, 0, 0, 0, "R11 banked set cpu1");
    acc(0, 12'h100, 4, 0, 1, 32'h1, 0, 0, "R11 banked read cpu1");
    acc(0, 12'h100, 4, 0, 0, 32'h0, 0, 0, "R11 banked read cpu0");

    acc(1, 12'h200, 4, 32'hFFFFFFFF, 0, 0, 0, 1, "R3 set pending word0 R9");
    acc(0, 12'h200, 4, 0, 0, 32'hFFFF0000, 0, 0, "R3 pending word0 masked");
    acc(1, 12'h280, 4, 32'hFFFFFFFF, 0, 0, 0, 1, "R3 clear pending word0 R9");
    acc(0, 12'h200, 4, 0, 0, 32'h0, 0, 0, "R3 pending word0 cleared");
    acc(1, 12'h204, 4, 32'h80000001, 0, 0, 0, 1, "R1 set pending word1");
    acc(0, 12'h204, 4, 0, 3, 32'h80000001, 0, 0, "R11 shared pending word1");
    acc(1, 12'h300, 4, 32'hF, 0, 0, 0, 0, "R3 active word0 unprotected");
    acc(0, 12'h380, 4, 0, 0, 32'hF, 0, 0, "R2 active via clear window");

    acc(1, 12'h405, 1, 32'hAA, 0, 0, 0, 1, "R4 prio byte write R9");
    acc(1, 12'h406, 2, 32'h1234, 0, 0, 0, 1, "R4 prio half write");
    acc(0, 12'h404, 4, 0, 0, 32'h1234AA00, 0, 0, "R4 prio word read");
    acc(0, 12'h406, 2, 0, 0, 32'h1234, 0, 0, "R4 prio half read");
    acc(0, 12'h405, 1, 0, 0, 32'hAA, 0, 0, "R4 prio byte read");
    acc(0, 12'h43E, 4, 0, 0, 0, 1, 0, "R4 prio past end");
    acc(0, 12'h43E, 2, 0, 0, 0, 0, 0, "R4 prio last two");

    acc(1, 12'h828, 4, 32'h04030201, 0, 0, 0, 1, "R5 target word write R9");
    acc(0, 12'h82A, 1, 0, 0, 32'h03, 0, 0, "R5 target byte read");
    acc(1, 12'h82D, 4, 32'h11223344, 0, 0, 0, 1, "R5 target unaligned write");
    acc(0, 12'h82C, 4, 0, 0, 32'h11223344, 0, 0, "R5 target aligned read");
    acc(0, 12'h828, 2, 0, 0, 0, 1, 0, "R5 target half rejected");

    acc(0, 12'h800, 4, 0, 2, 32'h04040404, 0, 0, "R6 low target word cpu2");
    acc(0, 12'h81F, 1, 0, 3, 32'h08, 0, 0, "R6 low target byte cpu3");
    acc(1, 12'h800, 4, 32'hFFFFFFFF, 0, 0, 0, 0, "R6 low target write ignored");

    acc(0, 12'h050, 4, 0, 0, 0, 1, 0, "R10 unmapped");
    acc(0, 12'h004, 3, 0, 0, 0, 1, 0, "R10 bad size");
    acc(1, 12'h108, 4, 32'hFFFFFFFF, 0, 0, 1, 0, "R10 word beyond lines");
    acc(1, 12'h104, 4, 32'hF0000000, 5, 0, 1, 0, "R10 bad cpu");
    acc(1, 12'h200, 0, 32'h00010000, 0, 0, 1, 0, "R10 size zero");
    idle(3);

    check("R8 dist_enable", {31'd0, dist_enable}, 32'd1);
    check("R11 cpu1 view bit0", {31'd0, en_vec[NL]}, 32'd1);
    check("R11 cpu0 view bit0", {31'd0, en_vec[0]}, 32'd0);
    check("R10 shared enable unchanged", en_vec[2*NL+32 +: 32], 32'hFC0);
    check("R1 pending vector", pend_vec[32 +: 32], 32'h80000001);
    check("R10 pending word0 untouched", pend_vec[31:0], 32'h0);
    check("R1 active vector", act_vec[31:0], 32'hF);
    check("R4 prio vector", {24'd0, prio_vec[5*8 +: 8]}, 32'hAA);
    check("R5 target vector", {24'd0, tgt_vec[41*8 +: 8]}, 32'h02);
    check("R6 low target stored", tgt_vec[31:0], 32'h0);
    check("R8 cfg vector", cfg_vec[32 +: 32], 32'hA5A50F0F);
    check("R12 all responses seen", 32'(q.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule